// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a simple 32-bit processor and works out, once per clock, where the next instruction fetch goes. The decoder supplies a small instruction-class code, the 16-bit branch displacement, the 26-bit jump index, a flag that says whether the two compared source registers are equal, and the register value used by indirect jumps. On the next rising edge the block loads the chosen address into its PC register.

Conditional branches are PC-relative. The displacement counts words, is signed, and is measured from the instruction that follows the branch. Direct jumps replace only the low 28 bits of that following address, so a direct jump always lands in the same 256 MB region as the instruction after it. The call form of the direct jump also registers a return address, together with a one-cycle write strobe meant for the link register of the register file. Indirect jumps take the register value unchanged.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the edge loads `pc_o`, `link_o` and `link_we_o` with zero.
- R2: Class codes 0, 6 and 7 are sequential. After the edge the PC equals the old PC + 4.
- R3: Class code 1 (branch-if-equal) with `regs_eq_i`=1 loads PC + 4 + (sign-extended `boff_i` × 4).
- R4: Class code 1 with `regs_eq_i`=0 loads PC + 4.
- R5: Class code 2 (branch-if-different) with `regs_eq_i`=0 loads PC + 4 + (sign-extended `boff_i` × 4). With `regs_eq_i`=1 it loads PC + 4.
- R6: The displacement is a two's-complement word count. A value with bit 15 set moves the PC backward, so 0xFFFF lands on the branch itself.
- R7: Class code 3 (direct jump) loads {(PC+4)[31:28], `jfield_i`, 2'b00}. For example, a field of 2500 in region 0 gives 10000.
- R8: The region bits of a direct jump come from PC + 4, not from PC. A jump at 0x0FFFFFFC therefore lands in region 1.
- R9: Class code 4 (call) loads the same target as R7. On the same edge `link_o` takes the old PC + 4, and `link_we_o` is 1 for that one cycle.
- R10: Class code 5 (indirect jump) loads `jr_val_i` bit for bit, including its two low bits.
- R11: For every class other than 4, `link_we_o` is 0 after the edge and `link_o` keeps its previous value.
- R12: `boff_i`, `jfield_i`, `regs_eq_i` and `jr_val_i` affect the PC only in the classes that name them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 3 | Instruction class code |
| boff_i | input | 16 | Signed word displacement of a branch |
| jfield_i | input | 26 | Word index of a direct jump |
| regs_eq_i | input | 1 | The two compared registers are equal |
| jr_val_i | input | 32 | Register value for an indirect jump |
| pc_o | output | 32 | Registered program counter |
| link_o | output | 32 | Registered return address |
| link_we_o | output | 1 | Return-address write strobe, one cycle |

## Verification
The case that is hardest to reach is a direct jump whose own address and following address lie in different 256 MB regions. Sequential stepping from reset would take tens of millions of cycles to get there. The bench instead uses an indirect jump to place the PC at 0x0FFFFFFC, then issues a direct jump and checks that the region comes from the following address. It places the PC near the top of the address space in the same way before testing backward branches and wrap-around. Apart from these set-ups, the bench sweeps every class code against both equality values and a set of extreme displacements and jump fields. A bench model of the PC tracks the expected value at every step.

// File: rtl/npc_pkg.sv
package npc_pkg;
  parameter int ADDR_W = 32;
  parameter int OFF_W  = 16;
  parameter int JF_W   = 26;
  parameter int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_SEQ  = 3'd0,
    CLS_BEQ  = 3'd1,
    CLS_BNE  = 3'd2,
    CLS_JMP  = 3'd3,
    CLS_CALL = 3'd4,
    CLS_IND  = 3'd5
  } npc_cls_e;
endpackage

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] pc_seq_o,
  output logic [ADDR_W-1:0] br_tgt_o
);
  localparam int EXT_W = ADDR_W - OFF_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] disp;

  // word displacement, sign-extended then scaled by four
  assign disp     = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign pc_seq_o = pc_i + STEP;
  assign br_tgt_o = pc_seq_o + disp;
endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc #(
  parameter int ADDR_W = 32,
  parameter int JF_W   = 26
) (
  input  logic [ADDR_W-1:0] pc_seq_i,
  input  logic [JF_W-1:0]   field_i,
  output logic [ADDR_W-1:0] jmp_tgt_o
);
  localparam int REGION_W = ADDR_W - JF_W - 2;

  generate
    if (REGION_W > 0) begin : g_region
      assign jmp_tgt_o = {pc_seq_i[ADDR_W-1 -: REGION_W], field_i, 2'b00};
    end else begin : g_flat
      assign jmp_tgt_o = {field_i[ADDR_W-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              eq_i,
  input  logic [ADDR_W-1:0] pc_seq_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  input  logic [ADDR_W-1:0] jmp_tgt_i,
  input  logic [ADDR_W-1:0] ind_tgt_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              call_o
);
  always_comb begin
    next_pc_o = pc_seq_i;
    call_o    = 1'b0;
    case (cls_i)
      CLS_BEQ:  if (eq_i)  next_pc_o = br_tgt_i;
      CLS_BNE:  if (!eq_i) next_pc_o = br_tgt_i;
      CLS_JMP:  next_pc_o = jmp_tgt_i;
      CLS_CALL: begin
        next_pc_o = jmp_tgt_i;
        call_o    = 1'b1;
      end
      CLS_IND:  next_pc_o = ind_tgt_i;
      default:  next_pc_o = pc_seq_i;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CLS_W-1:0]    cls_i,
  input  logic [OFF_W-1:0]    boff_i,
  input  logic [JF_W-1:0]     jfield_i,
  input  logic                regs_eq_i,
  input  logic [ADDR_W-1:0]   jr_val_i,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [ADDR_W-1:0]   link_o,
  output logic                link_we_o
);
  logic [ADDR_W-1:0] pc_seq;
  logic [ADDR_W-1:0] br_tgt;
  logic [ADDR_W-1:0] jmp_tgt;
  logic [ADDR_W-1:0] next_pc;
  logic              is_call;

  npc_branch_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_br (
    .pc_i     (pc_o),
    .off_i    (boff_i),
    .pc_seq_o (pc_seq),
    .br_tgt_o (br_tgt)
  );

  npc_jump_calc #(.ADDR_W(ADDR_W), .JF_W(JF_W)) u_jmp (
    .pc_seq_i  (pc_seq),
    .field_i   (jfield_i),
    .jmp_tgt_o (jmp_tgt)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .cls_i     (cls_i),
    .eq_i      (regs_eq_i),
    .pc_seq_i  (pc_seq),
    .br_tgt_i  (br_tgt),
    .jmp_tgt_i (jmp_tgt),
    .ind_tgt_i (jr_val_i),
    .next_pc_o (next_pc),
    .call_o    (is_call)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o      <= '0;
      link_o    <= '0;
      link_we_o <= 1'b0;
    end else begin
      pc_o      <= next_pc;
      link_we_o <= is_call;
      if (is_call) link_o <= pc_seq;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [CLS_W-1:0]    cls_i,
  input logic [OFF_W-1:0]    boff_i,
  input logic [JF_W-1:0]     jfield_i,
  input logic                regs_eq_i,
  input logic [ADDR_W-1:0]   jr_val_i,
  input logic [ADDR_W-1:0]   pc_o,
  input logic [ADDR_W-1:0]   link_o,
  input logic                link_we_o
);
  logic armed = 1'b0;
  logic run   = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
    run <= armed && !rst;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    armed && $past(rst) |-> (pc_o == '0 && link_o == '0 && !link_we_o));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    run && ($past(cls_i) == 3'd0 || $past(cls_i) == 3'd6 || $past(cls_i) == 3'd7)
    |-> pc_o == $past(pc_o) + 32'd4);

  // R3
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    run && $past(cls_i) == 3'd1 && $past(regs_eq_i)
    |-> pc_o == $past(pc_o) + 32'd4 + {{14{$past(boff_i[15])}}, $past(boff_i), 2'b00});

  // R4
  beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    run && $past(cls_i) == 3'd1 && !$past(regs_eq_i) |-> pc_o == $past(pc_o) + 32'd4);

  // R5
  bne_fall_chk: assert property (@(posedge clk) disable iff (rst)
    run && $past(cls_i) == 3'd2 && $past(regs_eq_i) |-> pc_o == $past(pc_o) + 32'd4);

  // R7
  jmp_low_chk: assert property (@(posedge clk) disable iff (rst)
    run && $past(cls_i) == 3'd3 |-> pc_o[27:0] == {$past(jfield_i), 2'b00});

  // R9
  call_link_chk: assert property (@(posedge clk) disable iff (rst)
    run && $past(cls_i) == 3'd4 |-> (link_we_o && link_o == $past(pc_o) + 32'd4));

  // R10
  ind_target_chk: assert property (@(posedge clk) disable iff (rst)
    run && $past(cls_i) == 3'd5 |-> pc_o == $past(jr_val_i));

  // R11
  link_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run && $past(cls_i) != 3'd4 |-> (!link_we_o && $stable(link_o)));
endmodule

bind npc_unit npc_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cls_i     (cls_i),
  .boff_i    (boff_i),
  .jfield_i  (jfield_i),
  .regs_eq_i (regs_eq_i),
  .jr_val_i  (jr_val_i),
  .pc_o      (pc_o),
  .link_o    (link_o),
  .link_we_o (link_we_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cls_i = '0;
  logic [15:0] boff_i = '0;
  logic [25:0] jfield_i = '0;
  logic        regs_eq_i = 1'b0;
  logic [31:0] jr_val_i = '0;
  logic [31:0] pc_o, link_o;
  logic        link_we_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] m_pc = '0;
  logic [31:0] m_link = '0;

  always #4 clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst(rst), .cls_i(cls_i), .boff_i(boff_i), .jfield_i(jfield_i),
    .regs_eq_i(regs_eq_i), .jr_val_i(jr_val_i), .pc_o(pc_o), .link_o(link_o),
    .link_we_o(link_we_o)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] off_pick(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'd25;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      4: return 16'h8000;
      default: return 16'hFFF0;
    endcase
  endfunction

  function automatic logic [25:0] jf_pick(input int k);
    case (k)
      0: return 26'd0;
      1: return 26'd2500;
      2: return 26'h3FFFFFF;
      default: return 26'h1555555;
    endcase
  endfunction

  // one instruction: drive at negedge, compare after the next rising edge
  task automatic step(input logic [2:0] c, input logic [15:0] o, input logic [25:0] j,
                      input logic e, input logic [31:0] r, input string req);
    logic [31:0] seq, exp_pc;
    logic        exp_we;
    cls_i = c; boff_i = o; jfield_i = j; regs_eq_i = e; jr_val_i = r;
    seq = m_pc + 32'd4;
    exp_pc = seq;
    exp_we = 1'b0;
    if ((c == 3'd1 && e) || (c == 3'd2 && !e))
      exp_pc = 32'($signed(seq) + $signed({{16{o[15]}}, o}) * 4);
    else if (c == 3'd3 || c == 3'd4)
      exp_pc = (seq & 32'hF000_0000) | (32'(j) * 32'd4);
    else if (c == 3'd5)
      exp_pc = r;
    if (c == 3'd4) begin
      m_link = seq;
      exp_we = 1'b1;
    end
    m_pc = exp_pc;
    @(posedge clk);
    #2;
    cmp(req, pc_o, exp_pc);
    cmp((c == 3'd4) ? "R9 link" : "R11 link", link_o, m_link);
    cmp((c == 3'd4) ? "R9 strobe" : "R11 strobe", {31'd0, link_we_o}, {31'd0, exp_we});
    @(negedge clk);
  endtask

  function automatic string req_of(input logic [2:0] c, input logic e, input logic [15:0] o);
    if (c == 3'd1) return e ? (o[15] ? "R6 beq back" : "R3 beq") : "R4 beq";
    if (c == 3'd2) return e ? "R5 bne fall" : (o[15] ? "R6 bne back" : "R5 bne");
    if (c == 3'd3) return "R7 jmp";
    if (c == 3'd4) return "R9 call";
    if (c == 3'd5) return "R10 ind";
    return "R2 seq";
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    cmp("R1 pc", pc_o, 32'd0);
    cmp("R1 link", link_o, 32'd0);
    cmp("R1 strobe", {31'd0, link_we_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R7 example: field 2500 from region 0 gives 10000
    step(3'd3, 16'h1234, 26'd2500, 1'b1, 32'hDEAD_BEEF, "R7 example");
    cmp("R7 value", pc_o, 32'd10000);
    // R3 example: displacement 25 gives +104
    step(3'd1, 16'd25, 26'd7, 1'b1, 32'h0, "R3 example");
    cmp("R3 value", pc_o, 32'd10104);
    // R6: 0xFFFF branches onto itself
    step(3'd2, 16'hFFFF, 26'd0, 1'b0, 32'h0, "R6 self");
    cmp("R6 value", pc_o, 32'd10104);

    // R8: region boundary, taken from PC + 4
    step(3'd5, 16'h0, 26'h0, 1'b0, 32'h0FFF_FFFC, "R10 setup");
    step(3'd3, 16'h0, 26'd4, 1'b0, 32'h0, "R8 boundary");
    cmp("R8 value", pc_o, 32'h1000_0010);
    step(3'd5, 16'h0, 26'h0, 1'b0, 32'h0FFF_FFFC, "R10 setup");
    step(3'd4, 16'h0, 26'd1, 1'b0, 32'h0, "R8 call boundary");
    cmp("R9 link value", link_o, 32'h1000_0000);

    // R10: low bits pass through
    step(3'd5, 16'hFFFF, 26'h3FFFFFF, 1'b1, 32'h1234_5673, "R10 odd");

    // R12: unused inputs have no effect on sequential steps
    step(3'd0, 16'h8000, 26'h3FFFFFF, 1'b1, 32'hFFFF_FFFF, "R12 seq");
    step(3'd6, 16'h7FFF, 26'h1555555, 1'b0, 32'h0, "R12 code6");
    step(3'd7, 16'hFFFF, 26'h2AAAAAA, 1'b1, 32'h5555_5555, "R12 code7");

    // top of address space, then sweep everything
    step(3'd5, 16'h0, 26'h0, 1'b0, 32'hF000_0100, "R10 setup high");
    for (int c = 0; c < 8; c++)
      for (int e = 0; e < 2; e++)
        for (int k = 0; k < 6; k++)
          for (int j = 0; j < 4; j++)
            step(3'(c), off_pick(k), jf_pick(j), 1'(e), 32'h8000_0000 + 32'(c * 4096 + k * 16 + j * 4),
                 req_of(3'(c), 1'(e), off_pick(k)));

    // R1 again: reset mid-run clears state
    rst = 1'b1;
    @(posedge clk);
    #2;
    cmp("R1 pc late", pc_o, 32'd0);
    cmp("R1 link late", link_o, 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule